// File: doc/BRIEF.md
# Prescaled 16-bit general-purpose timer

A single 16-bit timer driven by software through a five-word register bank. The count register steps up or down once per prescale period. A 16-bit divide value in the upper half of the control word sets that period. Software chooses the direction, and it chooses whether the timer stops after one terminal event (one-shot) or reloads itself and keeps going (auto-restart).

Control bits let software start, halt, reload and soft-reset the timer. A halt freezes both the count and the prescaler without losing either value. A reload copies the preload value into the count at once. A soft reset clears every register. Each terminal event sets a sticky status flag. While its enable bit is set, that flag drives a level interrupt.

The register port is synchronous. A write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. Byte offsets are: count 0x00, preload 0x04, status 0x08, interrupt enable 0x0C, control 0x10.

Top module: `gp_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Control word layout: bit 0 enable, bit 2 count-up (0 = down), bit 3 auto-restart (0 = one-shot), bit 4 soft reset, bit 5 start, bit 6 reload, bit 7 halt, bits 31:16 prescale P. Bits 1 and 15:8 always read 0, and so do the soft-reset and reload bits. Count and preload keep bits 15:0 only.
- R3: While running, the count takes its first step P+1 clocks after the write that sets start, and then one step every P+1 clocks. Writing start restarts the prescale period.
- R4: Counting down, the step that brings the count to 0 is the terminal event. In one-shot mode, that event sets status bit 0, leaves the count at 0 and clears the start bit.
- R5: Counting up, the step that would reach FFFFh is the terminal event. In auto-restart mode, that event loads the preload value instead, sets status bit 0 and leaves start at 1.
- R6: While halt is 1, the count does not change. After halt is cleared, counting resumes from the held value, one step per clock for P = 0.
- R7: A control write with reload set copies preload into count on that edge. The reload bit reads back as 0.
- R8: While enable is 0, a write of start is ignored: start reads 0 and the count does not change.
- R9: Writing 1 to status bit 0 clears it. Writing 0 to it has no effect.
- R10: `irq` equals status bit 0 AND interrupt-enable bit 0.
- R11: A control write with the soft-reset bit set returns all registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one edge per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The down-counting one-shot case is swept for prescale values 0 to 3, checking the count on every clock. This separates an off-by-one in the prescale period from an error in when the terminal event fires or in whether the count stops at 0. An up-counting auto-restart sweep over prescale 0 to 2 starts near FFFFh. It shows that the reload replaces the terminal value and that the count keeps wrapping through the preload range.

Separate sequences cover the remaining controls:
- halting mid-run;
- a reload while the timer is idle;
- a start write while enable is 0;
- writes of 0 and of 1 to the status flag;
- a soft reset.

Each sequence looks for a count that moves, or fails to move, when it should not.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned REG_W = 32;

  // register byte offsets
  localparam int unsigned OFS_COUNT   = 'h00;
  localparam int unsigned OFS_PRELOAD = 'h04;
  localparam int unsigned OFS_STATUS  = 'h08;
  localparam int unsigned OFS_INTEN   = 'h0C;
  localparam int unsigned OFS_CTRL    = 'h10;

  // control word bit positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_UP     = 2;
  localparam int unsigned CB_AUTO   = 3;
  localparam int unsigned CB_SRST   = 4;
  localparam int unsigned CB_START  = 5;
  localparam int unsigned CB_RELOAD = 6;
  localparam int unsigned CB_HALT   = 7;
  localparam int unsigned CB_PRESC  = 16;
endpackage

// File: rtl/gpt_rst_sync.sv
module gpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             wrap;

  assign wrap   = (pcnt_q >= presc_i);
  assign tick_o = run_i && !restart_i && wrap;

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart_i)  pcnt_d = '0;
    else if (run_i) pcnt_d = wrap ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pcnt_q == '0)); // R3
  AST_PRESC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> $stable(pcnt_q)); // R6
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic             auto_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             event_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, stepped, term;
  logic             override;

  assign stepped  = up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign term     = up_i ? {CNT_W{1'b1}} : '0;
  assign override = clr_i || wr_i || load_i;
  assign event_o  = tick_i && !override && (stepped == term);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (wr_i)    cnt_d = wdata_i;
    else if (load_i)  cnt_d = preload_i;
    else if (tick_i)  cnt_d = (event_o && auto_i) ? preload_i : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !override) |=> $stable(cnt_q)); // R6
  AST_ONESHOT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && !auto_i) |=> (cnt_q == $past(term))); // R4
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic rst_ni;
  logic wr_cnt, wr_pre, wr_sts, wr_ie, wr_ctl;
  logic srst, reload, restart, run, tick, evt;
  logic [CNT_W-1:0] cnt, preload_q, preload_d;
  logic status_q, status_d, ie_q, ie_d;
  logic en_q, en_d, up_q, up_d, auto_q, auto_d;
  logic start_q, start_d, halt_q, halt_d;
  logic [PRE_W-1:0] presc_q, presc_d;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[15:8], reg_wdata[1]};

  gpt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  assign wr_cnt  = reg_wr && (reg_addr == ADDR_W'(OFS_COUNT));
  assign wr_pre  = reg_wr && (reg_addr == ADDR_W'(OFS_PRELOAD));
  assign wr_sts  = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
  assign wr_ie   = reg_wr && (reg_addr == ADDR_W'(OFS_INTEN));
  assign wr_ctl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign srst    = wr_ctl && reg_wdata[CB_SRST];
  assign reload  = wr_ctl && !srst && reg_wdata[CB_RELOAD];
  assign restart = srst || (wr_ctl && reg_wdata[CB_START] && reg_wdata[CB_EN]);
  assign run     = en_q && start_q && !halt_q;

  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_ni), .run_i(run), .restart_i(restart),
    .presc_i(presc_q), .tick_o(tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .clr_i(srst), .wr_i(wr_cnt),
    .wdata_i(reg_wdata[CNT_W-1:0]), .load_i(reload), .preload_i(preload_q),
    .tick_i(tick), .up_i(up_q), .auto_i(auto_q), .cnt_o(cnt), .event_o(evt)
  );

  always_comb begin
    preload_d = preload_q;
    status_d  = status_q;
    ie_d      = ie_q;
    en_d      = en_q;
    up_d      = up_q;
    auto_d    = auto_q;
    start_d   = start_q;
    halt_d    = halt_q;
    presc_d   = presc_q;
    if (srst) begin
      preload_d = '0; status_d = 1'b0; ie_d = 1'b0; en_d = 1'b0; up_d = 1'b0;
      auto_d = 1'b0; start_d = 1'b0; halt_d = 1'b0; presc_d = '0;
    end else begin
      if (wr_pre) preload_d = reg_wdata[CNT_W-1:0];
      if (wr_ie)  ie_d = reg_wdata[0];
      if (evt)    status_d = 1'b1;
      else if (wr_sts && reg_wdata[0]) status_d = 1'b0;
      if (wr_ctl) begin
        en_d    = reg_wdata[CB_EN];
        up_d    = reg_wdata[CB_UP];
        auto_d  = reg_wdata[CB_AUTO];
        start_d = reg_wdata[CB_START] && reg_wdata[CB_EN];
        halt_d  = reg_wdata[CB_HALT];
        presc_d = reg_wdata[CB_PRESC +: PRE_W];
      end else if (evt && !auto_q) begin
        start_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      preload_q <= '0; status_q <= 1'b0; ie_q <= 1'b0; en_q <= 1'b0;
      up_q <= 1'b0; auto_q <= 1'b0; start_q <= 1'b0; halt_q <= 1'b0;
      presc_q <= '0;
    end else begin
      preload_q <= preload_d; status_q <= status_d; ie_q <= ie_d;
      en_q <= en_d; up_q <= up_d; auto_q <= auto_d; start_q <= start_d;
      halt_q <= halt_d; presc_q <= presc_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_COUNT):   reg_rdata = REG_W'(cnt);
      ADDR_W'(OFS_PRELOAD): reg_rdata = REG_W'(preload_q);
      ADDR_W'(OFS_STATUS):  reg_rdata[0] = status_q;
      ADDR_W'(OFS_INTEN):   reg_rdata[0] = ie_q;
      ADDR_W'(OFS_CTRL): begin
        reg_rdata[CB_EN]    = en_q;
        reg_rdata[CB_UP]    = up_q;
        reg_rdata[CB_AUTO]  = auto_q;
        reg_rdata[CB_START] = start_q;
        reg_rdata[CB_HALT]  = halt_q;
        reg_rdata[CB_PRESC +: PRE_W] = presc_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq = status_q && ie_q;

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt && !srst) |=> status_q); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt && !auto_q && !wr_ctl) |=> !start_q); // R4
  AST_AUTO_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt && auto_q && !wr_ctl) |=> (start_q && cnt == $past(preload_q))); // R5
  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_ni)
    reload |=> (cnt == $past(preload_q))); // R7
  AST_NO_EN_NO_START: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_ctl && !reg_wdata[CB_EN]) |=> !start_q); // R8
  AST_SRST_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    srst |=> (cnt == '0 && !status_q && !ie_q && !en_q && preload_q == '0)); // R11
endmodule

// File: tb/gp_timer_tb_top.sv
module gp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] A_CNT = 5'h00, A_PRE = 5'h04, A_STS = 5'h08,
                         A_IE = 5'h0C, A_CTL = 5'h10;

  always #4 clk = ~clk;

  gp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CNT, v); check("R1 count", v, 0);
    rd(A_PRE, v); check("R1 preload", v, 0);
    rd(A_STS, v); check("R1 status", v, 0);
    rd(A_IE, v);  check("R1 inten", v, 0);
    rd(A_CTL, v); check("R1 ctrl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 reserved bits read zero, fields kept
    wr(A_CTL, 32'h0003_FF8F);
    rd(A_CTL, v); check("R2 ctrl readback", v, 32'h0003_008D);
    wr(A_PRE, 32'hABCD_5678);
    rd(A_PRE, v); check("R2 preload width", v, 32'h0000_5678);

    // R3/R4 down one-shot sweep over prescale 0..3
    for (int p = 0; p < 4; p++) begin
      wr(A_CTL, 32'h10);
      wr(A_CNT, 32'd5);
      wr(A_CTL, 32'h21 | (p << 16));
      for (int k = 1; k <= 6 * (p + 1) + 3; k++) begin
        int n;
        int e;
        @(negedge clk);
        n = k / (p + 1);
        e = (n >= 5) ? 0 : 5 - n;
        rd(A_CNT, v); check($sformatf("R3 down p=%0d k=%0d", p, k), v, e);
        rd(A_STS, v); check($sformatf("R4 status p=%0d k=%0d", p, k), v, (n >= 5) ? 1 : 0);
      end
      rd(A_CTL, v); check($sformatf("R4 start cleared p=%0d", p), v, 32'h1 | (p << 16));
      check("R10 irq gated off", {31'b0, irq}, 0);
    end

    // R9/R10 status clear and interrupt gating (status is 1 here)
    wr(A_STS, 32'h0);
    rd(A_STS, v); check("R9 write zero keeps", v, 1);
    wr(A_IE, 32'h1);
    check("R10 irq on", {31'b0, irq}, 1);
    wr(A_STS, 32'h1);
    rd(A_STS, v); check("R9 write one clears", v, 0);
    check("R10 irq off after clear", {31'b0, irq}, 0);

    // R5 up auto-restart sweep over prescale 0..2
    for (int p = 0; p < 3; p++) begin
      wr(A_CTL, 32'h10);
      wr(A_PRE, 32'hFFFA);
      wr(A_CNT, 32'hFFFC);
      wr(A_IE, 32'h1);
      wr(A_CTL, 32'h2D | (p << 16));
      for (int k = 1; k <= 12 * (p + 1); k++) begin
        int n;
        int e;
        @(negedge clk);
        n = k / (p + 1);
        e = (n < 3) ? 32'hFFFC + n : 32'hFFFA + ((n - 3) % 5);
        rd(A_CNT, v); check($sformatf("R5 up p=%0d k=%0d", p, k), v, e);
        check($sformatf("R10 irq p=%0d k=%0d", p, k), {31'b0, irq}, (n >= 3) ? 1 : 0);
      end
      rd(A_CTL, v); check($sformatf("R5 start kept p=%0d", p), v, 32'h2D | (p << 16));
    end

    // R6 halt freezes and resumes
    wr(A_CTL, 32'h10);
    wr(A_CNT, 32'd100);
    wr(A_CTL, 32'h21);
    repeat (3) @(negedge clk);
    wr(A_CTL, 32'hA1);
    rd(A_CNT, c0);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); check("R6 held", v, c0);
    wr(A_CTL, 32'h21);
    rd(A_CNT, v); check("R6 no step on release edge", v, c0);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      rd(A_CNT, v); check($sformatf("R6 resume k=%0d", k), v, c0 - k);
    end

    // R7 reload while idle
    wr(A_CTL, 32'h10);
    wr(A_PRE, 32'h1234);
    wr(A_CTL, 32'h41);
    rd(A_CNT, v); check("R7 reload copy", v, 32'h1234);
    rd(A_CTL, v); check("R7 reload bit reads 0", v, 32'h1);

    // R8 start ignored with enable 0
    wr(A_CTL, 32'h10);
    wr(A_CNT, 32'h40);
    wr(A_CTL, 32'h20);
    rd(A_CTL, v); check("R8 start ignored", v, 0);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); check("R8 count idle", v, 32'h40);

    // R11 soft reset
    wr(A_PRE, 32'h77);
    wr(A_IE, 32'h1);
    wr(A_CTL, 32'h0005_00AD);
    wr(A_CTL, 32'h10);
    rd(A_CNT, v); check("R11 count", v, 0);
    rd(A_PRE, v); check("R11 preload", v, 0);
    rd(A_STS, v); check("R11 status", v, 0);
    rd(A_IE, v);  check("R11 inten", v, 0);
    rd(A_CTL, v); check("R11 ctrl", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule